// File: doc/BRIEF.md
# Reset-to-Default Flag Controller

This block keeps one status bit that tells firmware whether the front-panel button has asked for a return to factory settings. The bit is driven on `flag_o` at all times, so firmware can poll it whenever it likes. A value of 1 means normal operation. A value of 0 means the user has requested a restore.

The raw button contact is first passed through a two-flop synchronizer. It then goes through a debounce counter that must see a level held for `DEB_CYCLES` clocks before accepting it. The flag clears on the debounced release that follows a debounced press. The flag returns to 1 in two cases: a bus reset, or a host read cycle at a trigger address. The trigger address is not fixed. Its high and low bytes sit in two byte registers at fixed I/O locations, and the host can rewrite them to move it.

Firmware uses the block in three steps. It polls `flag_o`. It runs its restore routine when the bit reads 0. It then issues one read at the trigger address to acknowledge the request.

Top module: `dflt_flag_ctrl`

## Requirements
- R1: After `rst_ni` is released, `flag_o` is 1, the register at 0x0F57 reads 0xCD and the register at 0x0F56 reads 0xEF, so the trigger address is 0xCDEF.
- R2: A clock with `bus_rst_i` high sets `flag_o` to 1 from the next clock on. It also restores the register at 0x0F57 to 0xCD and the register at 0x0F56 to 0xEF.
- R3: A read strobe (`rd_i`) whose `addr_i` equals the current trigger address sets `flag_o` to 1 from the next clock on. If that address is not 0x0F56 or 0x0F57, the read returns 0x00.
- R4: Pressing the button means `btn_i` is 1 and the contact is closed. A press held for longer than `DEB_CYCLES` clocks leaves `flag_o` unchanged. The release that follows, once held for longer than `DEB_CYCLES` clocks, clears `flag_o` to 0.
- R5: Button pulses or gaps shorter than `DEB_CYCLES` clocks are ignored and do not change `flag_o`.
- R6: A write strobe (`wr_i`) at 0x0F57 loads `wdata_i` into trigger address bits [15:8]. A write strobe at 0x0F56 loads bits [7:0]. After such writes, reads at the old trigger address no longer set the flag, and reads at the new address do.
- R7: While `rd_i` is high, `rdata_o` is combinational. It shows trigger bits [15:8] for address 0x0F57 and trigger bits [7:0] for address 0x0F56. For any other address it shows 0x00. While `rd_i` is low, `rdata_o` is 0x00. A read at an address that is not the trigger address leaves `flag_o` unchanged.
- R8: When a set event (R2 or R3) and a debounced release fall in the same clock, the flag ends at 1.
- R9: Writes to any address other than 0x0F56 and 0x0F57 leave both address registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Synchronous bus reset, active high |
| addr_i | input | 16 | Host I/O address |
| rd_i | input | 1 | Host read strobe, one clock per read |
| wr_i | input | 1 | Host write strobe, one clock per write |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid while `rd_i` is high |
| btn_i | input | 1 | Raw button contact, 1 = closed |
| flag_o | output | 1 | Status flag: 1 = normal, 0 = restore requested |

## Verification
The assertions assume the following about the inputs:
- Each host read or write is a single-clock strobe.
- `rd_i` and `wr_i` are never high together.
- `btn_i` may bounce freely, because the debouncer absorbs it.

The stimulus keeps within these assumptions. Every host access is issued by a task that raises one strobe for exactly one clock and then drops it. The random phase picks addresses from three pools: the two address registers, the current trigger address, and arbitrary values. To reach the set-versus-clear priority case, the bench holds the bus reset across a whole debounced release, so the two events are sure to coincide.

// File: rtl/dflt_pkg.sv
package dflt_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t TRIG_RST   = 16'hCDEF;
  localparam addr_t HI_REG_ADR = 16'h0F57;
  localparam addr_t LO_REG_ADR = 16'h0F56;
endpackage

// File: rtl/dflt_sync.sv
module dflt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/dflt_debounce.sv
module dflt_debounce #(
  parameter int unsigned DEB_CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic level_o,
  output logic release_o
);
  localparam int unsigned CNT_W = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;
  logic             accept;

  assign accept = (sync_i != stable_q) && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (sync_i == stable_q) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q    <= '0;
      stable_q <= sync_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o   = stable_q;
  // Fires in the cycle the debounced level commits from closed to open.
  assign release_o = accept && stable_q;
endmodule

// File: rtl/dflt_addr_regs.sv
module dflt_addr_regs
  import dflt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bus_rst_i,
  input  addr_t addr_i,
  input  logic  rd_i,
  input  logic  wr_i,
  input  data_t wdata_i,
  output addr_t trig_o,
  output data_t rdata_o
);
  data_t hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= TRIG_RST[15:8];
      lo_q <= TRIG_RST[7:0];
    end else if (bus_rst_i) begin
      hi_q <= TRIG_RST[15:8];
      lo_q <= TRIG_RST[7:0];
    end else if (wr_i) begin
      if (addr_i == HI_REG_ADR) hi_q <= wdata_i;
      if (addr_i == LO_REG_ADR) lo_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == HI_REG_ADR)      rdata_o = hi_q;
      else if (addr_i == LO_REG_ADR) rdata_o = lo_q;
    end
  end

  assign trig_o = {hi_q, lo_q};
endmodule

// File: rtl/dflt_flag_ctrl.sv
module dflt_flag_ctrl
  import dflt_pkg::*;
#(
  parameter int unsigned DEB_CYCLES  = 65536,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_rst_i,
  input  logic [15:0] addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        btn_i,
  output logic        flag_o
);
  logic  btn_sync;
  logic  btn_level;
  logic  rel_pulse;
  addr_t trig_addr;
  logic  trig_hit;
  logic  set_evt;
  logic  flag_q;

  dflt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_i),
    .q_o   (btn_sync)
  );

  dflt_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (btn_sync),
    .level_o  (btn_level),
    .release_o(rel_pulse)
  );

  dflt_addr_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_rst_i(bus_rst_i),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .trig_o   (trig_addr),
    .rdata_o  (rdata_o)
  );

  assign trig_hit = rd_i && (addr_i == trig_addr);
  assign set_evt  = bus_rst_i || trig_hit;

  // Set events win over the button release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b1;
    else if (set_evt)   flag_q <= 1'b1;
    else if (rel_pulse) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dflt_flag_chk.sv
module dflt_flag_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_rst_i,
  input logic [15:0] addr_i,
  input logic        rd_i,
  input logic [7:0]  rdata_o,
  input logic        flag_o,
  input logic [15:0] trig_addr,
  input logic        rel_pulse
);
  p_bus_rst_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> flag_o);

  p_bus_rst_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (trig_addr == 16'hCDEF));

  p_trig_read_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == trig_addr) |=> flag_o);

  p_clear_by_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(rel_pulse));

  p_rise_has_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(bus_rst_i || (rd_i && addr_i == trig_addr)));

  p_idle_rdata_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 8'h00));

  p_set_priority_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_pulse && bus_rst_i) |=> flag_o);
endmodule

bind dflt_flag_ctrl dflt_flag_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bus_rst_i(bus_rst_i),
  .addr_i   (addr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .flag_o   (flag_o),
  .trig_addr(trig_addr),
  .rel_pulse(rel_pulse)
);

// File: tb/dflt_flag_ctrl_bench.sv
`timescale 1ns/1ps
module dflt_flag_ctrl_bench;
  localparam int unsigned DEB = 8;
  localparam int unsigned SETTLE = DEB + 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        btn = 1'b0;
  logic        flag;

  int unsigned n_tests = 0;
  int unsigned n_fail = 0;
  logic [15:0] m_trig = 16'hCDEF;
  logic        m_flag = 1'b1;

  always #5 clk = ~clk;

  dflt_flag_ctrl #(.DEB_CYCLES(DEB)) u_dflt_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .btn_i(btn), .flag_o(flag)
  );

  function automatic logic [7:0] exp_rdata(input logic [15:0] a, input logic [15:0] t);
    if (a == 16'h0F57) return t[15:8];
    if (a == 16'h0F56) return t[7:0];
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 check(req, 16'(rdata), 16'(exp_rdata(a, m_trig)));
    if (a == m_trig) m_flag = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(req, 16'(flag), 16'(m_flag));
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a == 16'h0F57) m_trig[15:8] = d;
    if (a == 16'h0F56) m_trig[7:0] = d;
  endtask

  task automatic press_release();
    btn = 1'b1;
    cycles(SETTLE);
    check("R4 press keeps flag", 16'(flag), 16'(m_flag));
    btn = 1'b0;
    cycles(SETTLE);
    m_flag = 1'b0;
    check("R4 release clears", 16'(flag), 16'(m_flag));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_0042);
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    // R1 reset state
    check("R1 flag", 16'(flag), 16'h1);
    do_read(16'h0F57, "R1 hi byte");
    do_read(16'h0F56, "R1 lo byte");

    // R4 clear, then R3 set by trigger read
    press_release();
    do_read(16'h1234, "R7 other read no set");
    do_read(16'hCDEF, "R3 trigger read sets");

    // R5 bounces
    press_release();
    do_read(16'hCDEF, "R3 re-set");
    for (int i = 0; i < 6; i++) begin
      btn = 1'b1; cycles(1 + (i % 4));
      btn = 1'b0; cycles(1 + (i % 3));
    end
    cycles(SETTLE);
    check("R5 short pulses ignored", 16'(flag), 16'h1);
    btn = 1'b1; cycles(SETTLE);
    btn = 1'b0; cycles(DEB / 2);
    btn = 1'b1; cycles(SETTLE);
    check("R5 short gap ignored", 16'(flag), 16'h1);
    btn = 1'b0; cycles(SETTLE);
    m_flag = 1'b0;
    check("R4 final release", 16'(flag), 16'h0);

    // R6 relocate trigger
    do_write(16'h0F57, 8'h12);
    do_write(16'h0F56, 8'h80);
    do_read(16'hCDEF, "R6 old address no set");
    do_read(16'h0F57, "R6 hi readback");
    do_read(16'h1280, "R6 new address sets");

    // R9 unrelated write
    do_write(16'h0F58, 8'hAA);
    do_write(16'h1280, 8'h55);
    do_read(16'h0F56, "R9 lo unchanged");
    do_read(16'h0F57, "R9 hi unchanged");

    // R7 idle rdata
    @(negedge clk); addr = 16'h0F57; #1;
    check("R7 idle rdata zero", 16'(rdata), 16'h0);

    // R2 bus reset
    press_release();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    m_flag = 1'b1; m_trig = 16'hCDEF;
    check("R2 flag set", 16'(flag), 16'h1);
    do_read(16'h0F57, "R2 hi restored");
    do_read(16'h0F56, "R2 lo restored");

    // R8 set beats clear: bus reset held across the release
    btn = 1'b1; cycles(SETTLE);
    @(negedge clk); bus_rst = 1'b1; btn = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      check("R8 set priority", 16'(flag), 16'h1);
    end
    bus_rst = 1'b0;
    cycles(2);
    check("R8 after window", 16'(flag), 16'h1);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      logic [15:0] a;
      k = $urandom_range(0, 15);
      case (k % 4)
        0: a = ($urandom_range(0, 1) != 0) ? 16'h0F57 : 16'h0F56;
        1: a = m_trig;
        default: a = 16'($urandom);
      endcase
      if (k == 15) press_release();
      else if (k >= 10) do_write(a, 8'($urandom));
      else do_read(a, "R3/R6/R7 random read");
    end
    do_read(m_trig, "R3 final trigger");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule